// File: doc/BRIEF.md
# Sequential Memory Read Engine

This block is the byte-level command layer of a small serial memory device. Bytes arrive from a lower bit-level layer on a valid strobe. The engine waits for the read-memory opcode. It then collects a 16-bit start address, sent low byte first. After that it returns one stored byte for each read request, walking forward through memory until the master stops or issues a reset.

Main storage is 512 bytes, seen as 16 pages of 32 bytes at addresses 0x0000 to 0x01FF. It is loaded through a simple preload port. The engine keeps the two target-address bytes exactly as the master sent them, and it also presents a read-only status byte. Neither the target-address bytes nor the status byte follow the running read pointer. Any location outside the main range reads back as all ones.

Top module: `memrd_engine`

## Requirements
- R1: After reset, a received byte 0xF0 starts a read command. The next two received bytes are taken as the address, low byte first (bits 7..0) and then high byte (bits 15..8), and appear on `ta_lo` and `ta_hi` once the high byte is taken.
- R2: While streaming, each cycle with `rd_req` high produces `tx_valid` high for exactly one cycle on the next clock edge, carrying one byte.
- R3: The bytes returned come from consecutive addresses starting at the supplied address, and the pointer advances by one per byte delivered.
- R4: Any address at or above 0x0200 returns 0xFF, whether the master supplied it directly or the pointer reached it by stepping past 0x01FF.
- R5: The 16-bit pointer holds at 0xFFFF instead of wrapping, so reads continue to return 0xFF.
- R6: `ta_lo` and `ta_hi` keep the supplied address while data streams out.
- R7: `stat_byte` is never changed by a read command. Its bits are: bit 7 completion flag, bit 6 always 0, bit 5 partial flag, bits 4..0 ending offset. Its value is parameter `STAT_RST` with bit 6 cleared.
- R8: A first byte other than 0xF0 makes the engine ignore all further bytes and read requests until reset.
- R9: `rst_n` low returns the engine to waiting for an opcode from any state and discards a partly received address.
- R10: Bytes received during streaming have no effect, and `rd_req` outside streaming produces no `tx_valid`.
- R11: A cycle with `pl_we` high writes `pl_data` into storage at `pl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (bus reset) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next data byte |
| tx_valid | output | 1 | Returned byte strobe |
| tx_byte | output | 8 | Returned byte |
| ta_lo | output | 8 | Target address bits 7..0 |
| ta_hi | output | 8 | Target address bits 15..8 |
| stat_byte | output | 8 | Read-only ending offset and status byte |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 9 | Preload address |
| pl_data | input | 8 | Preload data |

## Verification
The assertions check these on every cycle: the one-cycle request-to-byte latency, single pointer steps, saturation at 0xFFFF, all-ones data beyond the end of storage, stable target-address bytes during streaming, the sticky ignore state and a constant status byte. Only the bench scenarios can show the actual data values read from preloaded storage. They also show the low-then-high address order, the crossing from 0x01FF into the all-ones region, and the way a reset in the middle of an address throws away the partial address.

// File: rtl/memrd_pkg.sv
package memrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_LO = 3'd1,
        ST_ADDR_HI = 3'd2,
        ST_STREAM  = 3'd3,
        ST_HALT    = 3'd4
    } rd_state_e;

    localparam logic [7:0] OPC_READ = 8'hF0;
    localparam logic [7:0] FILL     = 8'hFF;
endpackage

// File: rtl/memrd_store.sv
module memrd_store #(
    parameter int MEM_BYTES = 512,
    parameter int AW        = $clog2(MEM_BYTES),
    parameter int PW        = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] raddr,
    output logic [7:0]    rdata
);
    import memrd_pkg::*;

    logic [7:0] mem [MEM_BYTES];
    logic       in_range;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        in_range = (raddr < PW'(MEM_BYTES));
        rdata    = in_range ? mem[raddr[AW-1:0]] : FILL;
    end
endmodule

// File: rtl/memrd_ctrl.sv
module memrd_ctrl #(
    parameter int         MEM_BYTES = 512,
    parameter int         PW        = 16,
    parameter logic [7:0] STAT_RST  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rd_req,
    input  logic [7:0]    mem_rdata,
    output logic [PW-1:0] mem_raddr,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic [7:0]    ta_lo,
    output logic [7:0]    ta_hi,
    output logic [7:0]    stat_byte
);
    import memrd_pkg::*;

    localparam logic [PW-1:0] PTR_MAX = '1;
    localparam logic [7:0]    STAT_0  = STAT_RST & 8'hBF;

    typedef struct packed {
        rd_state_e     st;
        logic [7:0]    lo_tmp;
        logic [7:0]    ta_lo;
        logic [7:0]    ta_hi;
        logic [PW-1:0] ptr;
        logic          txv;
        logic [7:0]    txb;
        logic [7:0]    stat;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  serve;

    always_comb begin
        r_d     = r_q;
        r_d.txv = 1'b0;
        serve   = (r_q.st == ST_STREAM) && rd_req;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rx_valid) begin
                    r_d.st = (rx_byte == OPC_READ) ? ST_ADDR_LO : ST_HALT;
                end
            end
            ST_ADDR_LO: begin
                if (rx_valid) begin
                    r_d.lo_tmp = rx_byte;
                    r_d.st     = ST_ADDR_HI;
                end
            end
            ST_ADDR_HI: begin
                if (rx_valid) begin
                    r_d.ta_lo = r_q.lo_tmp;
                    r_d.ta_hi = rx_byte;
                    r_d.ptr   = {rx_byte, r_q.lo_tmp};
                    r_d.st    = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (serve) begin
                    r_d.txv = 1'b1;
                    r_d.txb = mem_rdata;
                    if (r_q.ptr != PTR_MAX) begin
                        r_d.ptr = r_q.ptr + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.lo_tmp <= '0;
            r_q.ta_lo  <= '0;
            r_q.ta_hi  <= '0;
            r_q.ptr    <= '0;
            r_q.txv    <= 1'b0;
            r_q.txb    <= '0;
            r_q.stat   <= STAT_0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_raddr = r_q.ptr;
    assign tx_valid  = r_q.txv;
    assign tx_byte   = r_q.txb;
    assign ta_lo     = r_q.ta_lo;
    assign ta_hi     = r_q.ta_hi;
    assign stat_byte = r_q.stat;

    p_req_to_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM && rd_req) |=> tx_valid);

    p_no_stray_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.st == ST_STREAM && rd_req) |=> !tx_valid);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM && rd_req && r_q.ptr != PTR_MAX)
            |=> (r_q.ptr == $past(r_q.ptr) + 1'b1));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM && r_q.ptr == PTR_MAX) |=> (r_q.ptr == PTR_MAX));

    p_fill_beyond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM && rd_req && r_q.ptr >= PW'(MEM_BYTES))
            |=> (tx_byte == FILL));

    p_ta_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM) |=> $stable({ta_hi, ta_lo}));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HALT) |=> (r_q.st == ST_HALT && !tx_valid));

    p_stat_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_byte == STAT_0 && !stat_byte[6]));
endmodule

// File: rtl/memrd_engine.sv
module memrd_engine #(
    parameter int         MEM_BYTES = 512,
    parameter int         AW        = $clog2(MEM_BYTES),
    parameter int         PW        = 16,
    parameter logic [7:0] STAT_RST  = 8'hC3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rd_req,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic [7:0]    ta_lo,
    output logic [7:0]    ta_hi,
    output logic [7:0]    stat_byte,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [7:0]    pl_data
);
    logic [PW-1:0] raddr;
    logic [7:0]    rdata;

    memrd_store #(
        .MEM_BYTES(MEM_BYTES),
        .AW       (AW),
        .PW       (PW)
    ) u_store (
        .clk  (clk),
        .we   (pl_we),
        .waddr(pl_addr),
        .wdata(pl_data),
        .raddr(raddr),
        .rdata(rdata)
    );

    memrd_ctrl #(
        .MEM_BYTES(MEM_BYTES),
        .PW       (PW),
        .STAT_RST (STAT_RST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_req   (rd_req),
        .mem_rdata(rdata),
        .mem_raddr(raddr),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .ta_lo    (ta_lo),
        .ta_hi    (ta_hi),
        .stat_byte(stat_byte)
    );
endmodule

// File: tb/sim_memrd_engine.sv
module sim_memrd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rd_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte, ta_lo, ta_hi, stat_byte;
    logic       pl_we = 1'b0;
    logic [8:0] pl_addr = '0;
    logic [7:0] pl_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // {start address, byte count}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 16'd4},
        {16'h001E, 16'd4},
        {16'h01FD, 16'd6},
        {16'h0200, 16'd2},
        {16'h1234, 16'd2},
        {16'hFFFE, 16'd3}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    memrd_engine u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .ta_lo(ta_lo), .ta_hi(ta_hi), .stat_byte(stat_byte),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    function automatic logic [7:0] expect_at(input logic [15:0] a);
        logic [15:0] v;
        v = a * 16'd7 + 16'd3;
        return (a < 16'h0200) ? v[7:0] : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic read_one(input string req, input logic exp_v, input logic [7:0] exp_b);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check(req, {15'd0, tx_valid}, {15'd0, exp_v});
        if (exp_v) check(req, {8'd0, tx_byte}, {8'd0, exp_b});
        @(negedge clk);
        check("R2 single pulse", {15'd0, tx_valid}, 16'd0);
    endtask

    task automatic start_cmd(input logic [15:0] a);
        send(8'hF0);
        send(a[7:0]);
        send(a[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11 preload storage through the preload port
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = 9'(i); pl_data = expect_at(16'(i));
        end
        @(negedge clk); pl_we = 1'b0;
        rst_n = 1'b1;
        do_reset();

        // reset state
        check("R9 reset tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R9 reset ta", {ta_hi, ta_lo}, 16'h0000);
        check("R7 status layout", {8'd0, stat_byte}, 16'h0083);
        read_one("R10 req before command", 1'b0, 8'h00);

        // vector table walk (R1 R3 R4 R5 R6 R11)
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] a, n, p;
            a = VEC[v][31:16];
            n = VEC[v][15:0];
            do_reset();
            start_cmd(a);
            check("R1 address capture", {ta_hi, ta_lo}, a);
            p = a;
            for (int k = 0; k < int'(n); k++) begin
                read_one("R3 R4 R5 data", 1'b1, expect_at(p));
                if (p != 16'hFFFF) p = p + 1'b1;
            end
            check("R6 ta kept", {ta_hi, ta_lo}, a);
            check("R7 status kept", {8'd0, stat_byte}, 16'h0083);
        end

        // R10 bytes in stream ignored
        do_reset();
        start_cmd(16'h0040);
        send(8'h00);
        send(8'hF0);
        check("R10 ta unchanged", {ta_hi, ta_lo}, 16'h0040);
        read_one("R10 stream continues", 1'b1, expect_at(16'h0040));

        // R8 bad opcode then everything ignored
        do_reset();
        send(8'h55);
        start_cmd(16'h0010);
        check("R8 address ignored", {ta_hi, ta_lo}, 16'h0000);
        read_one("R8 no data", 1'b0, 8'h00);

        // R9 partial address discarded by reset
        do_reset();
        send(8'hF0);
        send(8'h77);
        do_reset();
        start_cmd(16'h0105);
        check("R9 fresh address", {ta_hi, ta_lo}, 16'h0105);
        read_one("R9 fresh data", 1'b1, expect_at(16'h0105));

        // R1 low byte first: bytes 0x01,0x00 give 0x0001
        do_reset();
        start_cmd(16'h0001);
        check("R1 byte order", {ta_hi, ta_lo}, 16'h0001);
        read_one("R1 byte order data", 1'b1, expect_at(16'h0001));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule